// File: doc/BRIEF.md
# Banked Interrupt Trigger Controller

The controller gathers peripheral interrupt lines, grouped in banks of 32, and folds them onto a small number of CPU trigger outputs. Each input number `n` belongs to bank `n / 32` at bit `n % 32`. Every bank holds three 32-bit registers: a status word, a sense word and a mask word. A sense bit of 1 makes the input level-sensitive. A sense bit of 0 makes it edge-sensitive. Every input also has its own small vector register, which names the trigger output it drives or disconnects it.

Software uses a single-cycle register port. Writing a 1 to a status bit toggles that bit instead of clearing it. Because of this, software can replay an interrupt by turning a status bit from 0 to 1. A trigger output is high while at least one input routed to it has both its status bit and its mask bit set.

Top module: `intc_trig_ctrl`

## Requirements
- R1: Reset clears every status, sense, mask and vector register and drives `trig_o` and `rdata_o` to zero. After reset, every input is edge-sensitive, masked and disconnected.
- R2: Address map for bank `b` (b < NUM_BANKS):
  - status at `0x000 + 8*b`
  - sense at `0x040 + 8*b`
  - mask at `0x080 + 8*b`
  - the vector of bank bit `k` at `0x1000*(b+1) + 8*k`

  Any other address (a bank at or above NUM_BANKS, low address bits not zero, register kind field `addr[7:6]=3`) reads as zero, and a write to it changes nothing.
- R3: In edge mode, a rising edge on `irq_i[n]` sets its status bit three clock edges after the input changes (two synchronizer flops, then capture). The bit stays set after the input falls.
- R4: In edge mode, writing 1 to a status bit toggles it and writing 0 leaves it unchanged. A write that turns the bit from 0 to 1 raises the routed trigger like a hardware event. Without a write, an edge-mode status bit never falls.
- R5: In level mode, the status bit follows the synchronized input level. A toggle write while the level is low sets the status bit for exactly one cycle. A toggle write while the level is high has no effect.
- R6: An input whose mask bit is 0 never drives a trigger output, but its status bit still records activity. Setting the mask bit later lets the pending status through.
- R7: A vector value `v` with `1 <= v <= NUM_TRIG` routes the input to `trig_o[v-1]`. A value of 0, or a value above NUM_TRIG, disconnects the input. Only the low `$clog2(NUM_TRIG+1)` bits of the write data are stored, so with 4 triggers, writing 8 stores 0.
- R8: `trig_o[t]` is a registered OR over all inputs with status=1, mask=1 and vector=t+1. It changes one clock edge after that condition changes.
- R9: A read (`req_i=1`, `we_i=0`) returns its data on `rdata_o` after the next clock edge. In any cycle after a non-read, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_BANKS*32 | Asynchronous peripheral interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| trig_o | output | NUM_TRIG | Registered CPU trigger outputs |

## Verification
A change on `irq_i` reaches the status register on the third rising edge and `trig_o` on the fourth. The bench drives at falling edges and samples `trig_o` at exactly those falling edges, including one check that the output is still low one edge early. A register write updates status, mask or vector at the edge where it is taken, and `trig_o` follows one edge later, so trigger checks come one falling edge after the write completes. Read data appears one edge after the request: the driver queues each expected word when it issues the read, and the monitor pops it at the following falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned BANK_BITS = 32;

  typedef enum logic [1:0] {
    REG_STAT  = 2'd0,
    REG_SENSE = 2'd1,
    REG_MASK  = 2'd2,
    REG_NONE  = 2'd3
  } bank_reg_e;

  typedef struct packed {
    logic      hit_bank;
    logic      hit_vec;
    bank_reg_e kind;
    logic [2:0] bank;
    logic [4:0] off;
  } dec_t;

  // bank regs: 0x000 | kind<<6 | bank<<3 ; vectors: 0x1000*(bank+1) | off<<3
  function automatic dec_t decode(logic [15:0] a, int unsigned nb);
    dec_t d;
    d = '0;
    d.kind = REG_NONE;
    if (a[15:12] == 4'd0 && a[11:8] == 4'd0 && a[2:0] == 3'd0 &&
        a[7:6] != 2'd3 && {29'd0, a[5:3]} < nb) begin
      d.hit_bank = 1'b1;
      d.kind     = bank_reg_e'(a[7:6]);
      d.bank     = a[5:3];
    end else if (a[15:12] != 4'd0 && {28'd0, a[15:12]} <= nb &&
                 a[11:8] == 4'd0 && a[2:0] == 3'd0) begin
      d.hit_vec = 1'b1;
      d.bank    = a[14:12] - 3'd1;
      d.off     = a[7:3];
    end
    return d;
  endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] lvl_i,
  input  logic [31:0] tog_i,
  input  logic        sense_we_i,
  input  logic        mask_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] stat_o,
  output logic [31:0] sense_o,
  output logic [31:0] mask_o
);
  logic [31:0] stat_q, sense_q, mask_q, lvl_d_q;
  logic [31:0] rise, stat_edge, stat_lvl, stat_d;

  assign rise      = lvl_i & ~lvl_d_q;
  // edge: toggle by software, set by a rising edge
  assign stat_edge = (stat_q ^ tog_i) | rise;
  // level: follow input; a toggle only matters while input is low
  assign stat_lvl  = lvl_i | tog_i;
  assign stat_d    = (sense_q & stat_lvl) | (~sense_q & stat_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      sense_q <= '0;
      mask_q  <= '0;
      lvl_d_q <= '0;
    end else begin
      stat_q  <= stat_d;
      lvl_d_q <= lvl_i;
      if (sense_we_i) sense_q <= wdata_i;
      if (mask_we_i)  mask_q  <= wdata_i;
    end
  end

  assign stat_o  = stat_q;
  assign sense_o = sense_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int unsigned N_IRQ  = 128,
  parameter int unsigned N_TRIG = 4,
  parameter int unsigned VEC_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vec_we_i,
  input  logic [7:0]        vec_idx_i,
  input  logic [VEC_W-1:0]  vec_wdata_i,
  input  logic [N_IRQ-1:0]  pend_i,
  output logic [VEC_W-1:0]  vec_rd_o,
  output logic [N_TRIG-1:0] trig_o
);
  logic [VEC_W-1:0]  vec_q [N_IRQ];
  logic [N_TRIG-1:0] trig_d, trig_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              vec_q[i] <= '0;
      else if (vec_we_i && vec_idx_i == 8'(i))  vec_q[i] <= vec_wdata_i;
    end
  end

  always_comb begin
    vec_rd_o = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (vec_idx_i == 8'(i)) vec_rd_o = vec_q[i];
  end

  always_comb begin
    trig_d = '0;
    for (int i = 0; i < N_IRQ; i++)
      for (int t = 0; t < N_TRIG; t++)
        if (pend_i[i] && vec_q[i] == VEC_W'(t + 1)) trig_d[t] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_d;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/intc_trig_ctrl.sv
module intc_trig_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_TRIG  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_BANKS*BANK_BITS-1:0] irq_i,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [15:0]                   addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic [NUM_TRIG-1:0]           trig_o
);
  localparam int unsigned N_IRQ = NUM_BANKS * BANK_BITS;
  localparam int unsigned VEC_W = $clog2(NUM_TRIG + 1);

  dec_t             dec;
  logic [N_IRQ-1:0] irq_s, stat_all, sense_all, mask_all;
  logic [VEC_W-1:0] vec_rd;
  logic [31:0]      rd_val, rdata_q;
  logic             vec_we;

  assign dec    = decode(addr_i, NUM_BANKS);
  assign vec_we = req_i && we_i && dec.hit_vec;

  intc_sync #(.W(N_IRQ)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = req_i && we_i && dec.hit_bank && (dec.bank == 3'(b));
    intc_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (irq_s[b*BANK_BITS +: BANK_BITS]),
      .tog_i     ((sel && dec.kind == REG_STAT) ? wdata_i : 32'd0),
      .sense_we_i(sel && dec.kind == REG_SENSE),
      .mask_we_i (sel && dec.kind == REG_MASK),
      .wdata_i   (wdata_i),
      .stat_o    (stat_all[b*BANK_BITS +: BANK_BITS]),
      .sense_o   (sense_all[b*BANK_BITS +: BANK_BITS]),
      .mask_o    (mask_all[b*BANK_BITS +: BANK_BITS])
    );
  end

  intc_route #(.N_IRQ(N_IRQ), .N_TRIG(NUM_TRIG), .VEC_W(VEC_W)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vec_we_i   (vec_we),
    .vec_idx_i  ({dec.bank, dec.off}),
    .vec_wdata_i(wdata_i[VEC_W-1:0]),
    .pend_i     (stat_all & mask_all),
    .vec_rd_o   (vec_rd),
    .trig_o     (trig_o)
  );

  always_comb begin
    rd_val = '0;
    if (dec.hit_bank) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (dec.bank == 3'(b)) begin
          case (dec.kind)
            REG_STAT:  rd_val = stat_all[b*BANK_BITS +: BANK_BITS];
            REG_SENSE: rd_val = sense_all[b*BANK_BITS +: BANK_BITS];
            REG_MASK:  rd_val = mask_all[b*BANK_BITS +: BANK_BITS];
            default:   rd_val = '0;
          endcase
        end
      end
    end else if (dec.hit_vec) begin
      rd_val = 32'(vec_rd);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (req_i && !we_i) ? rd_val : 32'd0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/intc_trig_ctrl_chk.sv
module intc_trig_ctrl_chk #(
  parameter int unsigned N_IRQ    = 128,
  parameter int unsigned NUM_TRIG = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_TRIG-1:0] trig_o,
  input logic [N_IRQ-1:0]    stat_all,
  input logic [N_IRQ-1:0]    sense_all,
  input logic [N_IRQ-1:0]    mask_all
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (trig_o == '0 && rdata_o == '0 && stat_all == '0 &&
                 mask_all == '0 && sense_all == '0));

  assert_rdata_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> (($past(stat_all) & ~$past(sense_all) & ~stat_all) == '0));

  assert_mask_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_all == '0) |=> trig_o == '0);

  assert_trig_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |-> ($past(stat_all & mask_all) != '0));
endmodule

bind intc_trig_ctrl intc_trig_ctrl_chk #(.N_IRQ(N_IRQ), .NUM_TRIG(NUM_TRIG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .trig_o   (trig_o),
  .stat_all (stat_all),
  .sense_all(sense_all),
  .mask_all (mask_all)
);

// File: tb/sim_intc_trig_ctrl.sv
module sim_intc_trig_ctrl;
  localparam int NB = 4;
  localparam int NT = 4;
  localparam int NI = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq;
  logic          req, we;
  logic [15:0]   addr;
  logic [31:0]   wdata, rdata;
  logic [NT-1:0] trig;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen;

  always #4 clk = ~clk;

  intc_trig_ctrl #(.NUM_BANKS(NB), .NUM_TRIG(NT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .trig_o(trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= req && !we;
  end

  // monitor: pops one expected word per completed read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_trig(input logic [NT-1:0] e, input string t);
    n_chk++;
    if (trig !== e) begin
      n_bad++;
      $display("FAIL %s: trig=%b expected=%b", t, trig, e);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    wait_n(3);
    chk_trig('0, "R1 trig in reset");
    rst_n = 1'b1;

    rd(16'h0000, 32'h0, "R1 status0 reset");
    rd(16'h0058, 32'h0, "R1 sense3 reset");
    rd(16'h0090, 32'h0, "R1 mask2 reset");
    rd(16'h1000, 32'h0, "R1 vector0 reset");
    chk_trig('0, "R1 trig after reset");

    // input 37: bank 1, bit 5
    wr(16'h0088, 32'h20);
    wr(16'h2028, 32'd1);
    rd(16'h2028, 32'd1, "R7 vector readback");
    rd(16'h0088, 32'h20, "R2 mask bank1");

    @(negedge clk); irq[37] = 1'b1;
    wait_n(3); chk_trig(4'b0000, "R8 trig not yet");
    wait_n(1); chk_trig(4'b0001, "R3 edge reaches trig");
    irq[37] = 1'b0;
    wait_n(5);
    rd(16'h0008, 32'h20, "R3 status held");
    chk_trig(4'b0001, "R3 trig held");

    wr(16'h0008, 32'h0);
    rd(16'h0008, 32'h20, "R4 zero write no effect");
    wr(16'h0008, 32'h20);
    wait_n(1); chk_trig(4'b0000, "R4 toggle clears");
    rd(16'h0008, 32'h0, "R4 status cleared");
    wr(16'h0008, 32'h20);
    wait_n(1); chk_trig(4'b0001, "R4 software retrigger");
    wr(16'h0008, 32'h20);
    wait_n(2);

    wr(16'h0088, 32'h0);
    @(negedge clk); irq[37] = 1'b1;
    wait_n(5); chk_trig(4'b0000, "R6 masked input");
    rd(16'h0008, 32'h20, "R6 status still records");
    wr(16'h0088, 32'h20);
    wait_n(1); chk_trig(4'b0001, "R6 unmask releases");
    irq[37] = 1'b0;
    wr(16'h0008, 32'h20);
    wait_n(2); chk_trig(4'b0000, "R4 cleared again");

    wr(16'h2028, 32'd3);
    wr(16'h0008, 32'h20);
    wait_n(1); chk_trig(4'b0100, "R7 vector 3 routes trig2");
    wr(16'h2028, 32'd5);
    wait_n(1); chk_trig(4'b0000, "R7 vector above range");
    rd(16'h2028, 32'd5, "R7 vector 5 stored");
    wr(16'h2028, 32'd8);
    rd(16'h2028, 32'd0, "R7 only low bits stored");
    chk_trig(4'b0000, "R7 vector 0 disconnects");

    // OR of inputs 37 and 127 on trig3
    wr(16'h2028, 32'd4);
    wr(16'h40F8, 32'd4);
    wr(16'h0098, 32'h8000_0000);
    wr(16'h0018, 32'h8000_0000);
    wait_n(1); chk_trig(4'b1000, "R8 two inputs on trig3");
    rd(16'h0018, 32'h8000_0000, "R2 status bank3 bit31");
    wr(16'h0008, 32'h20);
    wait_n(2); chk_trig(4'b1000, "R8 OR keeps other input");
    wr(16'h0018, 32'h8000_0000);
    wait_n(2); chk_trig(4'b0000, "R8 all cleared");

    // level mode on input 37, routed to trig1
    wr(16'h0048, 32'h20);
    wr(16'h2028, 32'd2);
    wr(16'h0008, 32'h20);
    chk_trig(4'b0000, "R5 pulse not yet out");
    wait_n(1); chk_trig(4'b0010, "R5 retrigger pulse");
    wait_n(1); chk_trig(4'b0000, "R5 pulse one cycle");
    @(negedge clk); irq[37] = 1'b1;
    wait_n(4);
    rd(16'h0008, 32'h20, "R5 status follows high");
    chk_trig(4'b0010, "R5 level drives trig1");
    wr(16'h0008, 32'h20);
    rd(16'h0008, 32'h20, "R5 toggle ignored while high");
    irq[37] = 1'b0;
    wait_n(4);
    rd(16'h0008, 32'h0, "R5 status follows low");

    wr(16'h0020, 32'hFFFF_FFFF);
    rd(16'h0020, 32'h0, "R2 bank4 status unmapped");
    wr(16'h5000, 32'd1);
    rd(16'h5000, 32'h0, "R2 vector bank4 unmapped");
    wr(16'h00C0, 32'hFFFF_FFFF);
    rd(16'h00C0, 32'h0, "R2 kind 3 unmapped");
    rd(16'h0004, 32'h0, "R2 misaligned read");
    rd(16'h0000, 32'h0, "R2 bank0 untouched");
    rd(16'h0080, 32'h0, "R2 mask0 untouched");
    wait_n(2);

    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: pending reads=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule